// File: doc/BRIEF.md
# Interrupt Status Aggregator with Normal and Fast Line Steering

This block gathers single-cycle hardware event pulses from up to 32 sources into sticky pending bits, masks them with per-bit enables, and steers each enabled pending bit onto one of two processor interrupt outputs. One output is a normal-priority line and the other is a fast line. A per-bit steering register selects the line for each source. Software can also force any pending bit from a dedicated set register.

Software reaches the block through a plain 32-bit register port. The port has a write strobe, a read strobe, a word address, write data and registered read data. There are four word registers at word addresses 8 to 11, which are byte offsets 0x20 to 0x2C. Word 8 is the pending register. Writing 1 to a bit of it clears that bit. Word 9 is the enable mask. Word 10 is the set register; writing 1 to a bit forces the pending bit, and reading it returns the pending register. Word 11 is the steering register.

The interrupt outputs are registered. Each output follows the pending, enable and steering state of the previous cycle.

Top module: `irq_dual_route`

## Requirements
- R1: After reset, all four registers read as zero and both interrupt outputs are low. The registers sit at word addresses 8 (pending), 9 (enable), 10 (set) and 11 (steering).
- R2: An event pulse on bit i sets pending bit i at the next clock edge, whatever the enable bit is. The bit then stays set without further pulses.
- R3: Writing word 8 clears each pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 are unchanged.
- R4: When an event pulse on bit i and a clear of bit i fall in the same cycle, pending bit i is 1 afterwards.
- R5: Writing word 10 sets each pending bit whose write-data bit is 1. A 0 in the write data leaves that pending bit unchanged.
- R6: A read of word 10 returns the current pending register.
- R7: The normal output equals the OR over all bits of (pending AND enable AND NOT steering), taken one cycle earlier.
- R8: The fast output equals the OR over all bits of (pending AND enable AND steering), taken one cycle earlier.
- R9: The enable (word 9) and steering (word 11) registers read back the last value written to them.
- R10: A read of any word address other than 8 to 11 returns zero. A write to such an address changes no register.
- R11: Read data is updated at the clock edge where the read strobe is high, and holds its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Hardware event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq_norm | output | 1 | Normal interrupt line |
| irq_fast | output | 1 | Fast interrupt line |

## Verification
Two functions can act on the same pending bit in the same cycle: a hardware event pulse and a software clear of that bit. For every bit position, the bench drives a clear-all write to the pending register in the same cycle as a pulse on that one bit. It then reads the register back and expects exactly that bit to remain set while all others are cleared. The steering and masking paths are swept per bit and across arithmetic mixes of enable and steering patterns. Each output is compared against the OR terms computed in the bench one cycle after the state changes.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Word addresses of the registers (byte offsets 0x20..0x2C)
    localparam int unsigned WORD_PEND  = 8;
    localparam int unsigned WORD_MASK  = 9;
    localparam int unsigned WORD_FORCE = 10;
    localparam int unsigned WORD_STEER = 11;

    typedef struct packed {
        logic pend;
        logic mask;
        logic force_set;
        logic steer;
    } reg_hit_t;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_hit_t          hit,
    output logic              hit_any
);

    always_comb begin
        hit.pend      = (addr == ADDR_W'(WORD_PEND));
        hit.mask      = (addr == ADDR_W'(WORD_MASK));
        hit.force_set = (addr == ADDR_W'(WORD_FORCE));
        hit.steer     = (addr == ADDR_W'(WORD_STEER));
        hit_any       = hit.pend | hit.mask | hit.force_set | hit.steer;
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr_we,
    input  logic               set_we,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] pend_q
);

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_SRC-1:0] clr_v, set_v, bit_d;

    assign clr_v = clr_we ? wbits : '0;
    assign set_v = set_we ? wbits : '0;

    // Per-bit next value: event and forced set win over clear
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        assign bit_d[g] = evt[g] | set_v[g] | (st_q.pend[g] & ~clr_v[g]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = bit_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;

    assert_evt_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((pend_q & $past(evt)) == $past(evt)));

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((pend_q & $past(wbits & ~evt & ~set_v)) == '0));

    assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && !set_we && evt == '0) |=> $stable(pend_q));

    assert_event_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && |(evt & wbits)) |=> ((pend_q & $past(evt)) == $past(evt)));

    assert_force_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((pend_q & $past(wbits)) == $past(wbits)));

endmodule

// File: rtl/irq_line_steer.sv
module irq_line_steer #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [NUM_SRC-1:0] steer,
    output logic               irq_norm_q,
    output logic               irq_fast_q
);

    typedef struct packed {
        logic norm;
        logic fast;
    } line_t;

    line_t ln_d, ln_q;
    logic [NUM_SRC-1:0] live;

    assign live = pend & mask;

    always_comb begin
        ln_d      = ln_q;
        ln_d.norm = |(live & ~steer);
        ln_d.fast = |(live & steer);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign irq_norm_q = ln_q.norm;
    assign irq_fast_q = ln_q.fast;

    assert_norm_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_norm_q == $past(|(pend & mask & ~steer))));

    assert_fast_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_fast_q == $past(|(pend & mask & steer))));

    assert_masked_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & mask) == '0) |=> (!irq_norm_q && !irq_fast_q));

endmodule

// File: rtl/irq_dual_route.sv
module irq_dual_route
    import irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_norm,
    output logic               irq_fast
);

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] steer;
        logic [DATA_W-1:0]  rd;
    } state_t;

    state_t st_d, st_q;
    reg_hit_t hit;
    logic hit_any;
    logic [NUM_SRC-1:0] pend_q, wbits;
    logic [DATA_W-1:0]  rd_mux;

    assign wbits = wdata[NUM_SRC-1:0];

    irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (addr),
        .hit     (hit),
        .hit_any (hit_any)
    );

    irq_status_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_i),
        .clr_we (wr_en & hit.pend),
        .set_we (wr_en & hit.force_set),
        .wbits  (wbits),
        .pend_q (pend_q)
    );

    irq_line_steer #(.NUM_SRC(NUM_SRC)) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend       (pend_q),
        .mask       (st_q.mask),
        .steer      (st_q.steer),
        .irq_norm_q (irq_norm),
        .irq_fast_q (irq_fast)
    );

    always_comb begin
        rd_mux = '0;
        if (hit.pend || hit.force_set) rd_mux = DATA_W'(pend_q);
        else if (hit.mask)             rd_mux = DATA_W'(st_q.mask);
        else if (hit.steer)            rd_mux = DATA_W'(st_q.steer);
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && hit.mask)  st_d.mask  = wbits;
        if (wr_en && hit.steer) st_d.steer = wbits;
        if (rd_en)              st_d.rd    = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rd;

    assert_force_reads_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(WORD_FORCE)) |=> (rdata == DATA_W'($past(pend_q))));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit_any) |=> (rdata == '0));

    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_any) |=> ($stable(st_q.mask) && $stable(st_q.steer)));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/irq_dual_route_test.sv
module irq_dual_route_test;

    localparam int unsigned N  = 32;
    localparam int unsigned AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt_i = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq_norm, irq_fast;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [31:0] m_pend = '0, m_mask = '0, m_steer = '0;

    always #2 clk = ~clk;

    irq_dual_route #(.NUM_SRC(N), .DATA_W(32), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        evt_i = v;
        @(negedge clk);
        evt_i = '0;
    endtask

    // Output lags state by one register stage; wait one more cycle, then sample
    task automatic chk_irq(input string tag);
        logic en_n, en_f;
        @(negedge clk);
        en_n = |(m_pend & m_mask & ~m_steer);
        en_f = |(m_pend & m_mask & m_steer);
        chk({tag, " norm"}, {31'd0, irq_norm}, {31'd0, en_n});
        chk({tag, " fast"}, {31'd0, irq_fast}, {31'd0, en_f});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 8; a < 12; a++) begin
            bus_rd(a, r);
            chk("R1 reset reg", r, 32'h0);
        end
        chk_irq("R1 reset irq");

        // Per-bit sweep
        for (int i = 0; i < N; i++) begin
            logic [31:0] b;
            b = 32'h1 << i;

            pulse(b); m_pend |= b;
            bus_rd(8, r); chk("R2 latch masked", r, m_pend);
            chk_irq("R7 masked quiet");

            bus_wr(9, b); m_mask = b;
            bus_wr(11, 32'h0); m_steer = 32'h0;
            chk_irq("R7 normal line");

            bus_wr(11, b); m_steer = b;
            chk_irq("R8 fast line");

            bus_wr(8, ~b);
            bus_rd(8, r); chk("R3 write zero keeps", r, m_pend);
            bus_wr(8, b); m_pend &= ~b;
            bus_rd(8, r); chk("R3 w1c", r, m_pend);
            chk_irq("R8 cleared quiet");

            // R4 collision: clear-all and event on bit i in one cycle
            @(negedge clk);
            wr_en = 1'b1; addr = AW'(8); wdata = 32'hFFFF_FFFF; evt_i = b;
            @(negedge clk);
            wr_en = 1'b0; evt_i = '0; wdata = '0;
            m_pend = b;
            bus_rd(8, r); chk("R4 event beats clear", r, b);
            bus_wr(8, b); m_pend = '0;

            bus_wr(10, b); m_pend |= b;
            bus_rd(10, r); chk("R5 R6 force and readback", r, m_pend);
            bus_wr(10, 32'h0);
            bus_rd(8, r); chk("R5 force zero no effect", r, m_pend);
            bus_wr(8, 32'hFFFF_FFFF); m_pend = '0;
        end

        // R9 readback patterns
        for (int k = 0; k < 4; k++) begin
            logic [31:0] p;
            p = 32'hA5C3_1E70 ^ (32'h1357_9BDF * k);
            bus_wr(9, p);  m_mask = p;
            bus_wr(11, ~p); m_steer = ~p;
            bus_rd(9, r);  chk("R9 mask readback", r, p);
            bus_rd(11, r); chk("R9 steer readback", r, ~p);
        end

        // Mixed steering sweep
        for (int k = 0; k < 24; k++) begin
            logic [31:0] pe, ma, sr;
            pe = (32'h9E37_79B9 * (k + 1)) >> (k % 5);
            ma = 32'h7F4A_7C15 * (k + 3);
            sr = 32'hC2B2_AE35 * (k + 7);
            if (k % 6 == 0) ma = 32'h0;
            if (k % 6 == 1) sr = 32'hFFFF_FFFF;
            if (k % 6 == 2) sr = 32'h0;
            bus_wr(8, 32'hFFFF_FFFF);
            bus_wr(10, pe); m_pend = pe;
            bus_wr(9, ma);  m_mask = ma;
            bus_wr(11, sr); m_steer = sr;
            chk_irq("R7 R8 mixed");
        end

        // R10 unmapped access
        bus_wr(3, 32'hDEAD_BEEF);
        bus_wr(12, 32'h1234_5678);
        bus_rd(3, r);  chk("R10 unmapped read", r, 32'h0);
        bus_rd(63, r); chk("R10 unmapped read high", r, 32'h0);
        bus_rd(9, r);  chk("R10 mask untouched", r, m_mask);
        bus_rd(11, r); chk("R10 steer untouched", r, m_steer);
        bus_rd(8, r);  chk("R10 pend untouched", r, m_pend);

        // R11 read data hold
        bus_wr(8, 32'hFFFF_FFFF); m_pend = '0;
        bus_rd(8, r); hold = r;
        pulse(32'h0000_8001); m_pend = 32'h0000_8001;
        repeat (2) @(negedge clk);
        chk("R11 rdata holds", rdata, hold);
        bus_rd(8, r); chk("R11 read updates", r, m_pend);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule